// File: doc/BRIEF.md
# Adaptive Link Poll Scheduler

This block decides when a supervisor should next look at the status of a single link. A one-cycle `tick_ms` input marks each millisecond, and the block emits a one-cycle `sample_stb` when a status sample is due. The caller's `link_up` level and `role_slave` level are read only in that strobe cycle.

A sample that finds the link up schedules the next sample at the slow link-up interval. A sample that finds the link down does three things. It raises a one-cycle `reset_req` for the link device. It notes the time at which the link was first seen down. It then schedules the next sample after a role-dependent hold-off plus a polling interval. The polling interval is short during the first seconds of an outage and long after that.

The two roles use different hold-off lengths. This keeps two identical partners from resetting in step with each other forever. Elapsed down time comes from a wrapping millisecond counter, using modular subtraction. A sticky flag keeps the slow rate once it has been reached.

Top module: `link_poll_sched`

## Requirements
- R1: While `rst_n` is low, `sample_stb` and `reset_req` are low and the down-time record is cleared. After release, the first strobe is due after the link-up interval (default 421 ticks).
- R2: An interval of N ticks is counted from a reference cycle: either the cycle after reset release or a strobe cycle. A tick that falls in a strobe cycle is not counted. `sample_stb` is high for exactly one clock, in the cycle after the cycle that carries the N-th counted tick.
- R3: A strobe that sees `link_up` = 1 sets the next interval to 421 ticks and clears the down-time record.
- R4: A strobe that sees `link_up` = 0 gives a one-cycle `reset_req` in the following cycle. A strobe that sees the link up gives none, and `reset_req` never rises at any other time.
- R5: The first down strobe after the record was cleared stores the current millisecond count. Down strobes whose elapsed time since that stored value is below 6000 ticks use the fast interval of 149 ticks.
- R6: From the first down strobe whose elapsed time is 6000 ticks or more, the interval is 1117 ticks. It stays at 1117 for all later down strobes until a strobe sees the link up.
- R7: After a down strobe, the next interval is the hold-off plus the polling interval. The hold-off is 97 ticks when `role_slave` = 0 (master) and 149 ticks when `role_slave` = 1 (slave), with the role read in the strobe cycle.
- R8: Elapsed down time is the modular difference of a free-running TS_W-bit millisecond counter. It stays correct when the counter wraps between the stored value and a later strobe.
- R9: Any polling interval parameter below 1 is treated as 1 tick. A hold-off is never shorter than the 1-tick post-reset stabilisation time.
- R10: Changes of `link_up` or `role_slave` outside a strobe cycle have no effect on the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| link_up | input | 1 | Link status, read in the strobe cycle |
| role_slave | input | 1 | 1 = slave role, 0 = master role, read in the strobe cycle |
| sample_stb | output | 1 | One-cycle request to sample the link status |
| reset_req | output | 1 | One-cycle request to reset the link device |

## Verification
The bench counts every tick it drives, leaving out those that fall in strobe cycles. It expects `sample_stb` exactly one clock after the tick that completes the current interval, and `reset_req` exactly one clock after a down strobe. Every negedge compares both outputs against these expectations, so a strobe that comes one cycle early or late is caught. The bench changes the link and role levels only outside strobe cycles. It computes the interval class from its own unbounded tick total, so counter wrap inside the design is checked against plain arithmetic. A second instance built with zero-valued interval parameters checks the one-tick floor and the stabilisation minimum.

// File: rtl/lps_pkg.sv
// Package: constant helpers shared by the poll scheduler modules.
// Assumes all arguments are non-negative elaboration-time values.
package lps_pkg;

    // Raise a zero interval to the one-tick floor.
    function automatic int unsigned floor_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    // Larger of two values.
    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lps_timebase.sv
// Module: free-running millisecond counter.
// Counts tick pulses modulo 2**TS_W; wrap is expected and harmless because
// consumers only take modular differences of its value.
module lps_timebase #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] now
);

    // Advance the count on every millisecond tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '0;
        end else if (tick) begin
            now <= now + 1'b1;
        end
    end

endmodule

// File: rtl/lps_down_tracker.sv
// Module: outage tracker. Stores the time of the first down sample and picks
// the fast or slow interval for down samples. Assumes FAST_WIN < 2**TS_W and
// that samples arrive more often than once per 2**TS_W - FAST_WIN ticks, so a
// wrapped difference is never mistaken for a short one before the sticky
// slow flag is set.
module lps_down_tracker #(
    parameter int TS_W     = 16,
    parameter int CNT_W    = 12,
    parameter int FAST_WIN = 6000,
    parameter int FAST_IV  = 149,
    parameter int SLOW_IV  = 1117
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             link_up,
    input  logic [TS_W-1:0]  now,
    output logic [CNT_W-1:0] down_iv
);

    localparam logic [TS_W-1:0]  WIN_TS  = TS_W'(FAST_WIN);
    localparam logic [CNT_W-1:0] FAST_C  = CNT_W'(FAST_IV);
    localparam logic [CNT_W-1:0] SLOW_C  = CNT_W'(SLOW_IV);

    logic            rec_valid;
    logic [TS_W-1:0] rec_start;
    logic            rec_slow;
    logic [TS_W-1:0] elapsed;
    logic            go_slow;

    // Elapsed outage time; zero on the sample that opens the record.
    always_comb begin
        elapsed = rec_valid ? (now - rec_start) : '0;
        go_slow = rec_slow || (elapsed >= WIN_TS);
        down_iv = go_slow ? SLOW_C : FAST_C;
    end

    // Open, extend or clear the outage record on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_start <= '0;
            rec_slow  <= 1'b0;
        end else if (sample) begin
            if (link_up) begin
                rec_valid <= 1'b0;
                rec_slow  <= 1'b0;
            end else begin
                if (!rec_valid) begin
                    rec_valid <= 1'b1;
                    rec_start <= now;
                end
                if (go_slow) begin
                    rec_slow <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lps_countdown.sv
// Module: tick countdown that fires a one-cycle strobe. A load in the fire
// cycle sets the next interval; ticks seen in that cycle are not counted.
// Assumes load_val >= 1.
module lps_countdown #(
    parameter int CNT_W = 12,
    parameter int INIT  = 421
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire
);

    localparam logic [CNT_W-1:0] INIT_C = CNT_W'(INIT);

    logic [CNT_W-1:0] remain;

    // Count ticks down and raise fire one cycle after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= INIT_C;
            fire   <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                remain <= load_val;
            end else if (tick) begin
                if (remain <= 1) begin
                    remain <= '0;
                    fire   <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/link_poll_sched.sv
// Module: adaptive link poll scheduler (top). Emits sample strobes at an
// interval chosen from the link state seen at the previous strobe, requests a
// device reset on each down sample, and inserts a role-dependent hold-off
// after it. Assumes tick_ms is a single-cycle pulse and that link_up and
// role_slave are valid in the strobe cycle.
module link_poll_sched #(
    parameter int UP_IV       = 421,
    parameter int FAST_IV     = 149,
    parameter int SLOW_IV     = 1117,
    parameter int FAST_WIN    = 6000,
    parameter int HOLD_MASTER = 97,
    parameter int HOLD_SLAVE  = 149,
    parameter int STAB_MS     = 1,
    parameter int TS_W        = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic link_up,
    input  logic role_slave,
    output logic sample_stb,
    output logic reset_req
);
    import lps_pkg::*;

    localparam int UP_C     = floor_one(UP_IV);
    localparam int FAST_C   = floor_one(FAST_IV);
    localparam int SLOW_C   = floor_one(SLOW_IV);
    localparam int HOLD_M_C = larger(HOLD_MASTER, floor_one(STAB_MS));
    localparam int HOLD_S_C = larger(HOLD_SLAVE, floor_one(STAB_MS));
    localparam int MAX_WAIT = larger(UP_C, larger(FAST_C, SLOW_C) + larger(HOLD_M_C, HOLD_S_C));
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic [TS_W-1:0]  now;
    logic [CNT_W-1:0] down_iv;
    logic [CNT_W-1:0] hold_iv;
    logic [CNT_W-1:0] next_iv;
    logic             req_q;

    lps_timebase #(.TS_W(TS_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_ms),
        .now   (now)
    );

    lps_down_tracker #(
        .TS_W     (TS_W),
        .CNT_W    (CNT_W),
        .FAST_WIN (FAST_WIN),
        .FAST_IV  (FAST_C),
        .SLOW_IV  (SLOW_C)
    ) u_down (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample_stb),
        .link_up (link_up),
        .now     (now),
        .down_iv (down_iv)
    );

    // Pick the next interval from the state seen in the strobe cycle.
    always_comb begin
        hold_iv = role_slave ? CNT_W'(HOLD_S_C) : CNT_W'(HOLD_M_C);
        next_iv = link_up ? CNT_W'(UP_C) : (down_iv + hold_iv);
    end

    lps_countdown #(
        .CNT_W (CNT_W),
        .INIT  (UP_C)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .load     (sample_stb),
        .load_val (next_iv),
        .fire     (sample_stb)
    );

    // Register the reset request one cycle after a down sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= sample_stb && !link_up;
        end
    end

    assign reset_req = req_q;

endmodule

// File: rtl/link_poll_sched_chk.sv
// Module: port-level property checker for link_poll_sched, bound below.
module link_poll_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_ms,
    input logic link_up,
    input logic sample_stb,
    input logic reset_req
);

    // R1: reset keeps both outputs low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!sample_stb && !reset_req));

    // R2: strobe lasts one cycle.
    assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R2: a strobe follows a tick.
    assert_stb_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(tick_ms));

    // R4: down sample requests a reset next cycle.
    assert_req_on_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !link_up) |=> reset_req);

    // R4: up sample requests no reset.
    assert_no_req_on_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && link_up) |=> !reset_req);

    // R4: a reset request only ever follows a strobe.
    assert_req_needs_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(sample_stb));

endmodule

bind link_poll_sched link_poll_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ms    (tick_ms),
    .link_up    (link_up),
    .sample_stb (sample_stb),
    .reset_req  (reset_req)
);

// File: tb/test_link_poll_sched.sv
module test_link_poll_sched;
    localparam int CLK_PERIOD = 10;
    localparam int TS_W       = 13;
    localparam int RUN_CYCLES = 60000;

    logic clk = 1'b0;
    logic rst_n, tick_ms, link_up, role_slave;
    logic sample_stb, reset_req, stb_min, req_min;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_poll_sched #(.TS_W(TS_W)) i_link_poll_sched (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .link_up(link_up),
        .role_slave(role_slave), .sample_stb(sample_stb), .reset_req(reset_req)
    );

    // R9: all intervals and hold-offs zero; link held down, master role.
    link_poll_sched #(.UP_IV(0), .FAST_IV(0), .SLOW_IV(0), .HOLD_MASTER(0),
                      .HOLD_SLAVE(0), .TS_W(TS_W)) i_link_poll_sched_min (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .link_up(1'b0),
        .role_slave(1'b0), .sample_stb(stb_min), .reset_req(req_min)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected next interval from the requirements (R3, R5, R6, R7).
    function automatic int expect_wait(input bit up, input bit slave, input bit slow);
        if (up) return 421;
        return (slow ? 1117 : 149) + (slave ? 149 : 97);
    endfunction

    function automatic bit tick_draw(input int cyc);
        return (cyc < 20000) ? (($urandom % 4) != 0) : (($urandom % 3) != 0);
    endfunction

    initial begin
        int exp_n, tcnt, total, dstart, m_n, mcnt;
        bit exp_stb, exp_req, dvalid, dover, m_exp_stb, m_exp_req, cur_stb, m_stb, nt;
        string tag;
        void'($urandom(32'd4242));
        rst_n = 1'b0; tick_ms = 1'b0; link_up = 1'b1; role_slave = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check(!sample_stb, "R1", "strobe in reset", sample_stb, 0);
                check(!reset_req, "R1", "reset_req in reset", reset_req, 0);
                check(!stb_min, "R1", "min strobe in reset", stb_min, 0);
            end
        end
        rst_n = 1'b1;
        exp_n = 421; tag = "R1"; tcnt = 0; total = 0; dstart = 0;
        exp_stb = 0; exp_req = 0; dvalid = 0; dover = 0;
        m_n = 1; mcnt = 0; m_exp_stb = 0; m_exp_req = 0;
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            @(negedge clk);
            // R2 timing of strobes and R4 timing of reset requests.
            check(sample_stb == exp_stb, tag, "sample_stb (R2)", sample_stb, exp_stb);
            check(reset_req == exp_req, "R4", "reset_req", reset_req, exp_req);
            check(stb_min == m_exp_stb, "R9", "min-instance strobe", stb_min, m_exp_stb);
            check(req_min == m_exp_req, "R9", "min-instance reset_req", req_min, m_exp_req);
            cur_stb = sample_stb;
            m_stb   = stb_min;
            exp_stb = 0; exp_req = 0; m_exp_stb = 0; m_exp_req = 0;
            if (cur_stb) begin
                if (link_up) begin
                    dvalid = 0; dover = 0; tag = "R3";
                end else begin
                    if (!dvalid) begin dvalid = 1; dstart = total; end
                    // R8: plain unbounded arithmetic versus the wrapping counter.
                    if (dover || (total - dstart) >= 6000) begin
                        dover = 1; tag = "R6 R7 R8";
                    end else begin
                        tag = "R5 R7";
                    end
                    exp_req = 1;
                end
                exp_n = expect_wait(link_up, role_slave, dover);
                tcnt = 0;
            end
            if (m_stb) begin
                // R9: floor of 1 tick plus 1 tick stabilisation hold-off.
                m_n = 2; mcnt = 0; m_exp_req = 1;
            end
            nt = tick_draw(cyc);
            // R10: link and role move only outside strobe cycles.
            if (!cur_stb) begin
                if (cyc < 2000) link_up = 1'b1;
                else if (cyc < 16000) begin
                    link_up = 1'b0;
                    if (($urandom % 500) == 0) role_slave = ~role_slave;
                end else if (cyc < 20000) link_up = 1'b1;
                else begin
                    if (($urandom % 700) == 0) link_up = ~link_up;
                    if (($urandom % 300) == 0) role_slave = ~role_slave;
                end
            end
            tick_ms = nt;
            if (nt) begin
                total++;
                if (!cur_stb) begin
                    tcnt++;
                    if (tcnt == exp_n) exp_stb = 1;
                end
                if (!m_stb) begin
                    mcnt++;
                    if (mcnt == m_n) m_exp_stb = 1;
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule